// File: doc/BRIEF.md
# Software-Loaded Set-Associative Translation Buffer

This block caches address translations that software places into it explicitly. Storage is split into a parameterised number of ways, each with a parameterised number of sets. An optional second half holds instruction-side entries apart from data-side ones. Every entry carries a page number and two opaque entry words. The first entry word carries the entry's valid flag in a fixed bit position.

A lookup takes an effective address and an instruction/data flag. One cycle later it returns, for every way, the two entry words held at the addressed set and a candidate flag. The candidate flag says whether that way's stored page number equals the page of the address. An external checker then decides permissions and the final hit.

Maintenance commands cover four actions:
- store an entry into a way named by software, after first removing any valid copy of the same page from the set;
- invalidate one set across all ways;
- invalidate everything, as a multi-cycle sweep during which the block stalls new requests;
- nothing (no operation).

The block also remembers the way most recently written.

Top module: `sw_tlb`

## Requirements
- R1: The set for an address is its page number (address shifted right by PAGE_BITS = 12) masked with SETS-1 (default 16 sets, so address bits 15:12). Entries of different pages in the same set occupy different ways without disturbing each other, and entries in other sets are untouched by set-level operations.
- R2: With the split option on (default), an access with the instruction flag = 1 uses a separate half of the storage, placed after all data entries. An entry stored with the instruction flag set is not seen by a data lookup of the same address, and the reverse also holds.
- R3: An accepted lookup produces `rsp_valid` exactly one cycle later. Way w's outputs sit at bit slice w*32 of each response bus. For each way the response carries:
  - a candidate bit, set when the stored page number equals the address page;
  - entry word 0, with bit 31 replaced by the entry's current valid flag;
  - entry word 1.
- R4: A store (mt_op = 0) writes the page number and both entry words into the named way at the addressed set. The entry's valid flag is taken from bit 31 of entry word 0.
- R5: Before writing, a store clears the valid flag of every way in the set whose stored page equals the store page. A way in that set holding a different page keeps its state.
- R6: Invalidate-by-address (mt_op = 1) clears the valid flag of every way at the addressed set, whatever page those ways hold. The other half and other sets are unaffected.
- R7: Invalidate-all (mt_op = 2) clears every valid flag in both halves. It does this by sweeping one row of all ways per cycle, with `busy` high for exactly SETS×halves cycles (32 by default).
- R8: While `busy` is high, `lk_ready` and `mt_ready` are low. A lookup or maintenance command offered then is not accepted: no response appears and no storage changes.
- R9: `last_way` takes the way number of each accepted store and is left unchanged by every other command.
- R10: When a store and a lookup to the same set are accepted in the same cycle, the lookup returns the contents from before the store.
- R11: After reset:
  - all valid flags are clear;
  - `busy` and `rsp_valid` are low;
  - `last_way` is 0;
  - both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted when high |
| lk_addr | input | ADDR_W | Lookup effective address |
| lk_code | input | 1 | Lookup is an instruction fetch |
| rsp_valid | output | 1 | Lookup response present |
| rsp_cand | output | WAYS | Per-way page-match candidate |
| rsp_w0 | output | WAYS*WORD_W | Per-way entry word 0, bit 31 = valid flag |
| rsp_w1 | output | WAYS*WORD_W | Per-way entry word 1 |
| mt_valid | input | 1 | Maintenance command request |
| mt_ready | output | 1 | Maintenance command accepted when high |
| mt_op | input | 2 | 0 store, 1 invalidate set, 2 invalidate all, 3 no operation |
| mt_addr | input | ADDR_W | Maintenance address |
| mt_code | input | 1 | Maintenance targets the instruction half |
| mt_way | input | WAY_W | Way for a store |
| mt_w0 | input | WORD_W | Entry word 0 for a store |
| mt_w1 | input | WORD_W | Entry word 1 for a store |
| busy | output | 1 | Invalidate-all sweep running |
| last_way | output | WAY_W | Way of the most recent store |

## Verification
The embedded properties hold on every cycle for several behaviours:
- the valid flag left by a store equals bit 31 of its word 0;
- a store clears duplicate copies of its page in the other ways;
- invalidate-by-address and each sweep row clear their targets;
- a sweep lasts exactly the row count, and never overlaps lookups or writes;
- a stalled lookup produces no response;
- `last_way` holds across commands that are not stores.

Other behaviours only the bench scenarios can show, because they need a model of contents over time:
- the old-contents result when a store and a lookup collide;
- the separation of the instruction and data halves;
- placement of entries by set;
- whether commands refused during a sweep leave storage untouched.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
  typedef enum logic [1:0] {
    MT_STORE    = 2'd0,
    MT_INV_ADDR = 2'd1,
    MT_INV_ALL  = 2'd2,
    MT_NOP      = 2'd3
  } mt_op_e;
endpackage

// File: rtl/sw_tlb_index.sv
// Turns an address and the instruction flag into a storage row and page number.
module sw_tlb_index #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 16,
  parameter int SPLIT     = 1,
  localparam int SET_W    = $clog2(SETS),
  localparam int PAGE_W   = ADDR_W - PAGE_BITS,
  localparam int ROW_W    = SET_W + ((SPLIT != 0) ? 1 : 0)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              code,
  output logic [ROW_W-1:0]  row,
  output logic [PAGE_W-1:0] page
);
  logic [SET_W-1:0] set_idx;
  logic             unused_offset;

  assign page          = addr[ADDR_W-1:PAGE_BITS];
  assign set_idx       = page[SET_W-1:0];
  assign unused_offset = ^addr[PAGE_BITS-1:0];

  generate
    if (SPLIT != 0) begin : g_split
      // instruction half sits above all data rows
      assign row = {code, set_idx};
    end else begin : g_shared
      logic unused_code;
      assign unused_code = code;
      assign row         = set_idx;
    end
  endgenerate
endmodule

// File: rtl/sw_tlb_sweep.sv
// Invalidate-all engine: one row per cycle across all ways.
module sw_tlb_sweep #(
  parameter int ROWS  = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [ROW_W-1:0] clr_row
);
  logic [ROW_W-1:0] ptr_q;
  logic             busy_q;
  logic [ROW_W:0]   run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (busy_q) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == ROW_W'(ROWS - 1)) busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end
  end

  assign busy    = busy_q;
  assign clr_row = ptr_q;

  // length of the current busy run, kept for the check below
  always_ff @(posedge clk) begin
    if (rst || start) run_len <= '0;
    else if (busy_q)  run_len <= run_len + 1'b1;
  end

  assert_sweep_len_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (run_len == (ROW_W + 1)'(ROWS)));
endmodule

// File: rtl/sw_tlb_way.sv
// One way: valid flags and page numbers in flops, entry words in inferable RAM.
module sw_tlb_way #(
  parameter int ROWS      = 32,
  parameter int PAGE_W    = 20,
  parameter int WORD_W    = 32,
  parameter int VALID_BIT = 31,
  localparam int ROW_W    = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_en,
  input  logic [ROW_W-1:0]  lk_row,
  input  logic [PAGE_W-1:0] lk_page,
  input  logic [ROW_W-1:0]  mt_row,
  input  logic [PAGE_W-1:0] mt_page,
  input  logic              st_en,
  input  logic              wr_en,
  input  logic              inv_en,
  input  logic [WORD_W-1:0] w0_in,
  input  logic [WORD_W-1:0] w1_in,
  input  logic              clr_en,
  input  logic [ROW_W-1:0]  clr_row,
  output logic              rd_cand,
  output logic [WORD_W-1:0] rd_w0,
  output logic [WORD_W-1:0] rd_w1
);
  logic [ROWS-1:0]   valid_q;
  logic [PAGE_W-1:0] epn_q [ROWS];
  logic [WORD_W-1:0] ram0  [ROWS];
  logic [WORD_W-1:0] ram1  [ROWS];
  logic [WORD_W-1:0] rd0_q, rd1_q;
  logic              cand_q, vld_q;
  logic              dup_hit, kill;

  assign dup_hit = (epn_q[mt_row] == mt_page);
  assign kill    = (st_en && dup_hit) || inv_en;

  // Valid flags: sweep clear, duplicate/set clear, then store write wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (clr_en) valid_q[clr_row] <= 1'b0;
      if (kill)   valid_q[mt_row]  <= 1'b0;
      if (wr_en)  valid_q[mt_row]  <= w0_in[VALID_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ROWS; i++) epn_q[i] <= '0;
    end else if (wr_en) begin
      epn_q[mt_row] <= mt_page;
    end
  end

  // Entry words: single write port, registered read, read-before-write.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      ram0[mt_row] <= w0_in;
      ram1[mt_row] <= w1_in;
    end
    if (lk_en) begin
      rd0_q <= ram0[lk_row];
      rd1_q <= ram1[lk_row];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (lk_en) begin
      cand_q <= (epn_q[lk_row] == lk_page);
      vld_q  <= valid_q[lk_row];
    end
  end

  always_comb begin
    rd_w0            = rd0_q;
    rd_w0[VALID_BIT] = vld_q;
  end
  assign rd_w1   = rd1_q;
  assign rd_cand = cand_q;

  assert_store_valid_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (valid_q[$past(mt_row)] == $past(w0_in[VALID_BIT])));

  assert_dup_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    (st_en && !wr_en && dup_hit) |=> !valid_q[$past(mt_row)]);

  assert_set_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    inv_en |=> !valid_q[$past(mt_row)]);

  assert_sweep_row_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !valid_q[$past(clr_row)]);

  assert_sweep_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> !(wr_en || inv_en || st_en || lk_en));
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int WAYS      = 2,
  parameter int SETS      = 16,
  parameter int SPLIT     = 1,
  parameter int WORD_W    = 32,
  parameter int VALID_BIT = 31,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lk_valid,
  output logic                     lk_ready,
  input  logic [ADDR_W-1:0]        lk_addr,
  input  logic                     lk_code,
  output logic                     rsp_valid,
  output logic [WAYS-1:0]          rsp_cand,
  output logic [WAYS*WORD_W-1:0]   rsp_w0,
  output logic [WAYS*WORD_W-1:0]   rsp_w1,
  input  logic                     mt_valid,
  output logic                     mt_ready,
  input  logic [1:0]               mt_op,
  input  logic [ADDR_W-1:0]        mt_addr,
  input  logic                     mt_code,
  input  logic [WAY_W-1:0]         mt_way,
  input  logic [WORD_W-1:0]        mt_w0,
  input  logic [WORD_W-1:0]        mt_w1,
  output logic                     busy,
  output logic [WAY_W-1:0]         last_way
);
  import sw_tlb_pkg::*;

  localparam int HALVES = (SPLIT != 0) ? 2 : 1;
  localparam int ROWS   = HALVES * SETS;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int PAGE_W = ADDR_W - PAGE_BITS;

  mt_op_e            op;
  logic              lk_fire, mt_fire, st_en, inv_en, all_en;
  logic [ROW_W-1:0]  lk_row, mt_row, clr_row;
  logic [PAGE_W-1:0] lk_page, mt_page;
  logic              busy_w;
  logic              rsp_q;
  logic [WAY_W-1:0]  last_q;

  assign op       = mt_op_e'(mt_op);
  assign lk_ready = !busy_w;
  assign mt_ready = !busy_w;
  assign lk_fire  = lk_valid && !busy_w;
  assign mt_fire  = mt_valid && !busy_w;
  assign st_en    = mt_fire && (op == MT_STORE);
  assign inv_en   = mt_fire && (op == MT_INV_ADDR);
  assign all_en   = mt_fire && (op == MT_INV_ALL);

  sw_tlb_index #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SETS(SETS), .SPLIT(SPLIT))
    u_lk_idx (.addr(lk_addr), .code(lk_code), .row(lk_row), .page(lk_page));

  sw_tlb_index #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SETS(SETS), .SPLIT(SPLIT))
    u_mt_idx (.addr(mt_addr), .code(mt_code), .row(mt_row), .page(mt_page));

  sw_tlb_sweep #(.ROWS(ROWS))
    u_sweep (.clk(clk), .rst(rst), .start(all_en), .busy(busy_w), .clr_row(clr_row));

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic              wr_en;
      logic              cand;
      logic [WORD_W-1:0] w0, w1;

      assign wr_en = st_en && (mt_way == WAY_W'(w));

      sw_tlb_way #(.ROWS(ROWS), .PAGE_W(PAGE_W), .WORD_W(WORD_W), .VALID_BIT(VALID_BIT))
        u_way (
          .clk(clk), .rst(rst),
          .lk_en(lk_fire), .lk_row(lk_row), .lk_page(lk_page),
          .mt_row(mt_row), .mt_page(mt_page),
          .st_en(st_en), .wr_en(wr_en), .inv_en(inv_en),
          .w0_in(mt_w0), .w1_in(mt_w1),
          .clr_en(busy_w), .clr_row(clr_row),
          .rd_cand(cand), .rd_w0(w0), .rd_w1(w1)
        );

      assign rsp_cand[w]                = cand;
      assign rsp_w0[w*WORD_W +: WORD_W] = w0;
      assign rsp_w1[w*WORD_W +: WORD_W] = w1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q  <= 1'b0;
      last_q <= '0;
    end else begin
      rsp_q <= lk_fire;
      if (st_en) last_q <= mt_way;
    end
  end

  assign rsp_valid = rsp_q;
  assign last_way  = last_q;
  assign busy      = busy_w;

  assert_stall_no_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_w && lk_valid) |=> !rsp_valid);

  assert_last_way_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!(mt_valid && mt_ready && (mt_op == 2'd0))) |=> $stable(last_way));

  assert_last_way_take_R9: assert property (@(posedge clk) disable iff (rst)
    (mt_valid && mt_ready && (mt_op == 2'd0)) |=> (last_way == $past(mt_way)));
endmodule

// File: tb/sim_sw_tlb.sv
module sim_sw_tlb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_code, lk_ready;
  logic [31:0] lk_addr;
  logic        rsp_valid;
  logic [1:0]  rsp_cand;
  logic [63:0] rsp_w0, rsp_w1;
  logic        mt_valid, mt_ready, mt_code;
  logic [1:0]  mt_op;
  logic [31:0] mt_addr, mt_w0, mt_w1;
  logic [0:0]  mt_way;
  logic        busy;
  logic [0:0]  last_way;

  sw_tlb u0 (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr), .lk_code(lk_code),
    .rsp_valid(rsp_valid), .rsp_cand(rsp_cand), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1),
    .mt_valid(mt_valid), .mt_ready(mt_ready), .mt_op(mt_op), .mt_addr(mt_addr),
    .mt_code(mt_code), .mt_way(mt_way), .mt_w0(mt_w0), .mt_w1(mt_w1),
    .busy(busy), .last_way(last_way)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string       tag;
    logic [1:0]  cand;
    logic [1:0]  vb;
    logic [1:0]  known;
    logic [63:0] w0;
    logic [63:0] w1;
  } exp_t;
  exp_t exq[$];

  // reference contents, indexed [half][way][set]
  logic        mv [2][2][16];
  logic [19:0] mp [2][2][16];
  logic [31:0] mw0[2][2][16];
  logic [31:0] mw1[2][2][16];
  bit          mk [2][2][16];
  string       lk_tag;

  function automatic void chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic void model_reset();
    for (int h = 0; h < 2; h++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 16; s++) begin
          mv[h][w][s] = 0; mp[h][w][s] = '0; mk[h][w][s] = 0;
          mw0[h][w][s] = '0; mw1[h][w][s] = '0;
        end
  endfunction

  // monitor: compare responses in order
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exq.size() == 0) chk("R3 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = exq.pop_front();
        chk({e.tag, " cand"}, rsp_cand, e.cand);
        for (int w = 0; w < 2; w++) begin
          chk({e.tag, " valid bit"}, rsp_w0[w*32+31], e.vb[w]);
          if (e.known[w]) begin
            chk({e.tag, " word0"}, rsp_w0[w*32 +: 32], e.w0[w*32 +: 32]);
            chk({e.tag, " word1"}, rsp_w1[w*32 +: 32], e.w1[w*32 +: 32]);
          end
        end
      end
    end
  end

  // driver: one clock step, updating expectations before the edge
  task automatic tick();
    if (lk_valid && !busy) begin
      exp_t e;
      int h, s;
      h = lk_code; s = lk_addr[15:12];
      e.tag = lk_tag;
      for (int w = 0; w < 2; w++) begin
        logic [31:0] x;
        e.cand[w]  = (mp[h][w][s] == lk_addr[31:12]);
        e.vb[w]    = mv[h][w][s];
        e.known[w] = mk[h][w][s];
        x = mw0[h][w][s]; x[31] = mv[h][w][s];
        e.w0[w*32 +: 32] = x;
        e.w1[w*32 +: 32] = mw1[h][w][s];
      end
      exq.push_back(e);
    end
    if (mt_valid && !busy) begin
      int h, s;
      h = mt_code; s = mt_addr[15:12];
      if (mt_op == 2'd0) begin
        for (int w = 0; w < 2; w++)
          if (mp[h][w][s] == mt_addr[31:12]) mv[h][w][s] = 0;
        mv[h][mt_way][s]  = mt_w0[31];
        mp[h][mt_way][s]  = mt_addr[31:12];
        mw0[h][mt_way][s] = mt_w0;
        mw1[h][mt_way][s] = mt_w1;
        mk[h][mt_way][s]  = 1;
      end else if (mt_op == 2'd1) begin
        for (int w = 0; w < 2; w++) mv[h][w][s] = 0;
      end else if (mt_op == 2'd2) begin
        for (int hh = 0; hh < 2; hh++)
          for (int w = 0; w < 2; w++)
            for (int ss = 0; ss < 16; ss++) mv[hh][w][ss] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0;
    mt_valid = 0;
  endtask

  task automatic set_lookup(logic [31:0] a, logic c, string tag);
    lk_valid = 1; lk_addr = a; lk_code = c; lk_tag = tag;
  endtask

  task automatic set_mt(logic [1:0] op, logic [31:0] a, logic c, logic w,
                        logic [31:0] d0, logic [31:0] d1);
    mt_valid = 1; mt_op = op; mt_addr = a; mt_code = c; mt_way = w;
    mt_w0 = d0; mt_w1 = d1;
  endtask

  task automatic lookup(logic [31:0] a, logic c, string tag);
    set_lookup(a, c, tag); tick();
  endtask

  task automatic store(logic [31:0] a, logic c, logic w, logic [31:0] d0, logic [31:0] d1);
    set_mt(2'd0, a, c, w, d0, d1); tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    lk_valid = 0; lk_addr = '0; lk_code = 0;
    mt_valid = 0; mt_op = 2'd3; mt_addr = '0; mt_code = 0; mt_way = 0;
    mt_w0 = '0; mt_w1 = '0;
    model_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R11: reset state
    chk("R11 busy", busy, 0);
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 last_way", last_way, 0);
    chk("R11 ready", {lk_ready, mt_ready}, 2'b11);
    lookup(32'h0000_5000, 0, "R11 empty lookup");

    // R4 / R3: store into way 0, set 5
    store(32'h1234_5000, 0, 0, 32'h8000_1111, 32'hAAAA_0001);
    chk("R9 last_way after store way0", last_way, 0);
    lookup(32'h1234_5abc, 0, "R3 R4 lookup way0");

    // R1: another page in the same set goes to way 1
    store(32'h0001_5000, 0, 1, 32'h8000_2222, 32'hAAAA_0002);
    chk("R9 last_way after store way1", last_way, 1);
    lookup(32'h0001_5000, 0, "R1 same set two ways");

    // R1: different set
    store(32'h0000_6000, 0, 0, 32'h8000_3333, 32'hAAAA_0003);
    lookup(32'h0000_6004, 0, "R1 other set");

    // R2: instruction half separate
    lookup(32'h1234_5000, 1, "R2 code half empty");
    store(32'h1234_5000, 1, 0, 32'h8000_4444, 32'hBBBB_0004);
    lookup(32'h1234_5000, 0, "R2 data unchanged");
    lookup(32'h1234_5000, 1, "R2 code half entry");

    // R5: same page into way 1 clears way 0 copy
    store(32'h1234_5000, 0, 1, 32'h8000_5555, 32'hAAAA_0005);
    lookup(32'h1234_5000, 0, "R5 duplicate cleared");

    // R4: store with valid bit clear
    store(32'h0002_7000, 0, 1, 32'h0000_6666, 32'hAAAA_0006);
    lookup(32'h0002_7000, 0, "R4 stored invalid");

    // R10: same-cycle store and lookup in set 5
    set_lookup(32'h1234_5000, 0, "R10 old contents");
    set_mt(2'd0, 32'h7777_5000, 0, 0, 32'h8000_7777, 32'hAAAA_0007);
    tick();
    lookup(32'h7777_5000, 0, "R10 new contents after");

    // R6: invalidate set 5, data half only
    set_mt(2'd1, 32'h9999_5000, 0, 0, '0, '0); tick();
    chk("R9 last_way kept by invalidate", last_way, 0);
    lookup(32'h7777_5000, 0, "R6 set cleared");
    lookup(32'h1234_5000, 1, "R6 code half kept");
    lookup(32'h0000_6000, 0, "R6 other set kept");

    // R7 / R8: invalidate all with stalled requests
    set_mt(2'd2, '0, 0, 0, '0, '0); tick();
    n = 0;
    while (busy && n < 100) begin
      if (n == 0) chk("R8 ready low while busy", {lk_ready, mt_ready}, 2'b00);
      if (n == 3) begin
        set_lookup(32'h0000_6000, 0, "R8 stalled");
        set_mt(2'd0, 32'hABCD_3000, 0, 0, 32'h8000_8888, 32'h0);
      end
      n++;
      tick();
    end
    chk("R7 sweep length", n, 32);
    chk("R9 last_way kept by sweep", last_way, 0);
    chk("R8 ready after sweep", {lk_ready, mt_ready}, 2'b11);
    lookup(32'h0000_6000, 0, "R7 data cleared");
    lookup(32'h1234_5000, 1, "R7 code cleared");
    lookup(32'hABCD_3000, 0, "R8 refused store absent");

    repeat (3) @(negedge clk);
    chk("R3 all responses seen", exq.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule